// File: doc/BRIEF.md
# Serial Configuration Register-Write Slave

This block receives register writes over a three-wire synchronous serial link and holds the results in a small bank of configuration registers. The serial clock, an active-low enable and a data line arrive from an external host. All three are oversampled in the system clock domain, so the serial clock may be arbitrarily slow and need not have a 50% duty cycle. While the enable is low, one data bit is taken on each rising edge of the serial clock, and every 24 such bits form one frame.

A frame is sent most significant bit first. It carries a read/write flag (0 selects a write), a marker bit that must be 1, a 14-bit register address and an 8-bit data byte. Several frames may follow one another inside one enable window. Bits left over after the last complete frame are discarded when the enable rises, and the next window always starts a fresh frame. The bank is returned to its defaults by the system reset, by a pulse on a hardware reset input, or by writing a 1 to bit 0 of register 6. That bit clears itself.

Top module: `sercfg_write_slave`

## Requirements
- R1: After the system reset `rst_n` is low, register i holds its default value `DEFAULT_BASE + i`. With the default parameters that is 0xA0 + i, so register 6 defaults to 0xA6 and its bit 0 is 0.
- R2: Serial clock edges have no effect while `ser_en_n_i` is high. Bits are captured only on rising serial clock edges that occur while the enable is low.
- R3: A frame is 24 bits sent MSB first: bit 23 is the read/write flag, bit 22 the marker, bits 21..8 the address and bits 7..0 the data. When the flag is 0 and the marker is 1, the data byte is written to the addressed register on the 24th rising edge.
- R4: Two or more complete frames sent back to back inside one enable window are each written, in order.
- R5: When the enable rises, any bits after the last complete frame cause no write. The bit count restarts at zero in the next window.
- R6: A frame whose flag is 1, or whose marker is 0, changes no register.
- R7: A frame whose full 14-bit address is not below `NUM_REGS` changes no register. An address such as 0x2002 does not alias onto register 2.
- R8: When a write sets bit 0 of register 6, all registers return to their defaults on the next system clock. The bit is therefore high for exactly one cycle.
- R9: `hw_reset_i` high at a system clock edge loads the defaults at that edge. It takes priority over a frame that completes in the same cycle.
- R10: Frames are received correctly with serial clocks many hundreds of system cycles long and with unequal high and low times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low system reset |
| hw_reset_i | input | 1 | Active-high register reset pulse, synchronous to `clk` |
| ser_clk_i | input | 1 | Serial clock from the host (asynchronous) |
| ser_en_n_i | input | 1 | Active-low serial enable (asynchronous) |
| ser_data_i | input | 1 | Serial data, sampled on the serial clock rise |
| regs_o | output | NUM_REGS*8 | Register bank contents; register i in bits [8i+7:8i] |

## Verification
A completing frame and a hardware reset pulse can land in the same system clock cycle. In that case the reset must win, and the frame's byte must not appear afterwards. The bench provokes this collision by raising the hardware reset just before the 24th serial rising edge and holding it through the cycles in which the synchronized edge completes the frame. It judges the outcome by checking, once the window closes, that every register is at its default and that the earlier writes are also gone. The self-clearing reset bit is the second case where a write and a reset follow each other closely. There the bench counts how many system cycles bit 0 of register 6 stays high, and the count must be exactly one.

// File: rtl/sercfg_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the serial configuration write slave.
// The frame layout is fixed by the link protocol and is not a parameter.
package sercfg_pkg;

    localparam int FRAME_W = 24;
    localparam int ADDR_W  = 14;
    localparam int DATA_W  = 8;

    // Frame as received, first transmitted bit in the MSB.
    typedef struct packed {
        logic              rd_flag;   // 1 = read request (not served)
        logic              marker;    // must be 1 for a valid write
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } cfg_frame_t;

    // Default content of register idx.
    function automatic logic [DATA_W-1:0] reg_default(input int idx,
                                                      input logic [DATA_W-1:0] base);
        return base + DATA_W'(idx);
    endfunction

endpackage

// File: rtl/sercfg_sync.sv
`timescale 1ns/1ps
// Brings the three serial link lines into the clk domain and flags each
// rising edge of the serial clock.
// Assumes: STAGES >= 2; clk is fast enough that each serial clock phase
// lasts at least two clk periods and data is stable across the rise.
module sercfg_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ser_clk_i,
    input  logic ser_en_n_i,
    input  logic ser_data_i,
    output logic sclk_rise_o,
    output logic en_active_o,
    output logic sdata_o
);

    logic [STAGES-1:0] sclk_pipe;
    logic [STAGES-1:0] en_pipe;
    logic [STAGES-1:0] data_pipe;
    logic              sclk_last;

    // Synchronizer chains; the enable resets to its inactive level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_pipe <= '0;
            en_pipe   <= '1;
            data_pipe <= '0;
            sclk_last <= 1'b0;
        end else begin
            sclk_pipe <= {sclk_pipe[STAGES-2:0], ser_clk_i};
            en_pipe   <= {en_pipe[STAGES-2:0], ser_en_n_i};
            data_pipe <= {data_pipe[STAGES-2:0], ser_data_i};
            sclk_last <= sclk_pipe[STAGES-1];
        end
    end

    // Rising-edge flag and synchronized line values.
    assign sclk_rise_o = sclk_pipe[STAGES-1] & ~sclk_last;
    assign en_active_o = ~en_pipe[STAGES-1];
    assign sdata_o     = data_pipe[STAGES-1];

endmodule

// File: rtl/sercfg_deframer.sv
`timescale 1ns/1ps
// Shifts in one bit per synchronized serial clock rise while the enable is
// active, and emits a one-cycle valid with the complete frame every
// FRAME_W bits. An inactive enable discards any partial frame.
// Assumes: at most one bit strobe per clk cycle.
module sercfg_deframer
    import sercfg_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       bit_strobe_i,
    input  logic                       en_active_i,
    input  logic                       bit_i,
    output logic                       frame_valid_o,
    output cfg_frame_t                 frame_o,
    output logic [$clog2(FRAME_W)-1:0] bit_count_o
);

    localparam int CNT_W = $clog2(FRAME_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_W - 1);

    logic [CNT_W-1:0]   bit_cnt;
    logic [FRAME_W-2:0] shift_q;

    // Bit counting, shifting and frame completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt       <= '0;
            shift_q       <= '0;
            frame_valid_o <= 1'b0;
            frame_o       <= '0;
        end else begin
            frame_valid_o <= 1'b0;
            if (!en_active_i) begin
                bit_cnt <= '0;
            end else if (bit_strobe_i) begin
                if (bit_cnt == LAST_BIT) begin
                    bit_cnt       <= '0;
                    frame_valid_o <= 1'b1;
                    frame_o       <= {shift_q, bit_i};
                end else begin
                    bit_cnt <= bit_cnt + 1'b1;
                    shift_q <= {shift_q[FRAME_W-3:0], bit_i};
                end
            end
        end
    end

    assign bit_count_o = bit_cnt;

endmodule

// File: rtl/sercfg_regbank.sv
`timescale 1ns/1ps
// Register bank: applies valid write frames, reloads defaults on a
// hardware reset pulse or when the self-clearing reset bit is set.
// Assumes: SWRST_ADDR < NUM_REGS, SWRST_BIT < DATA_W; frames arrive at
// least two clk cycles apart.
module sercfg_regbank
    import sercfg_pkg::*;
#(
    parameter int                NUM_REGS     = 8,
    parameter int                SWRST_ADDR   = 6,
    parameter int                SWRST_BIT    = 0,
    parameter logic [DATA_W-1:0] DEFAULT_BASE = 8'hA0
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         hw_reset_i,
    input  logic                         frame_valid_i,
    input  cfg_frame_t                   frame_i,
    output logic [NUM_REGS*DATA_W-1:0]   regs_o
);

    logic [NUM_REGS*DATA_W-1:0] regs_flat;
    logic                       sw_reset_req;
    logic                       write_ok;

    // A write needs the write flag, the marker and an in-range address.
    assign write_ok = frame_valid_i && !frame_i.rd_flag && frame_i.marker &&
                      (frame_i.addr < ADDR_W'(NUM_REGS));

    // The reset bit acts on the cycle after it was written.
    assign sw_reset_req = regs_flat[SWRST_ADDR*DATA_W + SWRST_BIT];

    for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_cell
        localparam logic [DATA_W-1:0] CELL_DEF = reg_default(gi, DEFAULT_BASE);
        logic [DATA_W-1:0] cell_q;

        // One register: resets take priority over a write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cell_q <= CELL_DEF;
            end else if (hw_reset_i || sw_reset_req) begin
                cell_q <= CELL_DEF;
            end else if (write_ok && (frame_i.addr == ADDR_W'(gi))) begin
                cell_q <= frame_i.data;
            end
        end

        assign regs_flat[gi*DATA_W +: DATA_W] = cell_q;
    end

    assign regs_o = regs_flat;

endmodule

// File: rtl/sercfg_write_slave.sv
`timescale 1ns/1ps
// Top level: serial configuration write slave. Synchronizes the serial
// link, assembles 24-bit frames and commits writes into a register bank.
// Assumes: hw_reset_i is synchronous to clk; clk at least four times the
// serial clock rate.
module sercfg_write_slave
    import sercfg_pkg::*;
#(
    parameter int                NUM_REGS     = 8,
    parameter int                SYNC_STAGES  = 2,
    parameter int                SWRST_ADDR   = 6,
    parameter int                SWRST_BIT    = 0,
    parameter logic [DATA_W-1:0] DEFAULT_BASE = 8'hA0
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       hw_reset_i,
    input  logic                       ser_clk_i,
    input  logic                       ser_en_n_i,
    input  logic                       ser_data_i,
    output logic [NUM_REGS*DATA_W-1:0] regs_o
);

    logic                       sclk_rise;
    logic                       en_active;
    logic                       sdata;
    logic                       frame_valid;
    cfg_frame_t                 frame;
    logic [$clog2(FRAME_W)-1:0] bit_cnt;

    sercfg_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk         (clk),
        .rst_n       (rst_n),
        .ser_clk_i   (ser_clk_i),
        .ser_en_n_i  (ser_en_n_i),
        .ser_data_i  (ser_data_i),
        .sclk_rise_o (sclk_rise),
        .en_active_o (en_active),
        .sdata_o     (sdata)
    );

    sercfg_deframer u_defr (
        .clk           (clk),
        .rst_n         (rst_n),
        .bit_strobe_i  (sclk_rise),
        .en_active_i   (en_active),
        .bit_i         (sdata),
        .frame_valid_o (frame_valid),
        .frame_o       (frame),
        .bit_count_o   (bit_cnt)
    );

    sercfg_regbank #(
        .NUM_REGS     (NUM_REGS),
        .SWRST_ADDR   (SWRST_ADDR),
        .SWRST_BIT    (SWRST_BIT),
        .DEFAULT_BASE (DEFAULT_BASE)
    ) u_bank (
        .clk           (clk),
        .rst_n         (rst_n),
        .hw_reset_i    (hw_reset_i),
        .frame_valid_i (frame_valid),
        .frame_i       (frame),
        .regs_o        (regs_o)
    );

endmodule

// File: rtl/sercfg_write_slave_chk.sv
`timescale 1ns/1ps
// Property checker for sercfg_write_slave, attached by bind below.
module sercfg_write_slave_chk
    import sercfg_pkg::*;
#(
    parameter int                NUM_REGS     = 8,
    parameter int                SWRST_ADDR   = 6,
    parameter int                SWRST_BIT    = 0,
    parameter logic [DATA_W-1:0] DEFAULT_BASE = 8'hA0
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       hw_reset_i,
    input logic                       en_active,
    input logic                       frame_valid,
    input cfg_frame_t                 frame,
    input logic [$clog2(FRAME_W)-1:0] bit_cnt,
    input logic [NUM_REGS*DATA_W-1:0] regs
);

    // Default image of the whole bank.
    function automatic logic [NUM_REGS*DATA_W-1:0] all_defaults();
        logic [NUM_REGS*DATA_W-1:0] v;
        for (int i = 0; i < NUM_REGS; i++) v[i*DATA_W +: DATA_W] = reg_default(i, DEFAULT_BASE);
        return v;
    endfunction

    localparam logic [NUM_REGS*DATA_W-1:0] DEFS = all_defaults();

    logic sw_bit;
    assign sw_bit = regs[SWRST_ADDR*DATA_W + SWRST_BIT];

    // R1: system reset loads the defaults.
    a_r1_reset_defaults: assert property (@(posedge clk)
        !rst_n |=> regs == DEFS);

    // R5: bit counter never passes the frame length.
    a_r5_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt < $clog2(FRAME_W)'(FRAME_W));

    // R5: an inactive enable clears the partial frame.
    a_r5_idle_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !en_active |=> bit_cnt == '0);

    // R3: registers change only on a frame or a reset.
    a_r3_no_spurious_change: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_valid && !hw_reset_i && !sw_bit) |=> $stable(regs));

    // R6: read or unmarked frames leave the bank alone.
    a_r6_bad_frame_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_valid && (frame.rd_flag || !frame.marker) && !hw_reset_i && !sw_bit)
        |=> $stable(regs));

    // R7: out-of-range addresses leave the bank alone.
    a_r7_range_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_valid && (frame.addr >= ADDR_W'(NUM_REGS)) && !hw_reset_i && !sw_bit)
        |=> $stable(regs));

    // R8: the reset bit clears itself and restores defaults.
    a_r8_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
        sw_bit |=> (!sw_bit && regs == DEFS));

    // R9: hardware reset wins over anything in the same cycle.
    a_r9_hw_reset: assert property (@(posedge clk) disable iff (!rst_n)
        hw_reset_i |=> regs == DEFS);

endmodule

bind sercfg_write_slave sercfg_write_slave_chk #(
    .NUM_REGS     (NUM_REGS),
    .SWRST_ADDR   (SWRST_ADDR),
    .SWRST_BIT    (SWRST_BIT),
    .DEFAULT_BASE (DEFAULT_BASE)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .hw_reset_i  (hw_reset_i),
    .en_active   (en_active),
    .frame_valid (frame_valid),
    .frame       (frame),
    .bit_cnt     (bit_cnt),
    .regs        (regs_o)
);

// File: tb/tb_sercfg_write_slave.sv
`timescale 1ns/1ps
// Directed bench for sercfg_write_slave: one task per scenario.
module tb_sercfg_write_slave;

    localparam int NREG = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             hw_reset_i = 1'b0;
    logic             ser_clk_i = 1'b0;
    logic             ser_en_n_i = 1'b1;
    logic             ser_data_i = 1'b0;
    logic [NREG*8-1:0] regs_o;

    int total = 0;
    int bad = 0;
    logic [7:0] exp_reg [NREG];

    int sw_hi_cycles = 0;
    int sw_long = 0;
    logic sw_prev = 1'b0;

    always #10 clk = ~clk;

    sercfg_write_slave dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .hw_reset_i (hw_reset_i),
        .ser_clk_i  (ser_clk_i),
        .ser_en_n_i (ser_en_n_i),
        .ser_data_i (ser_data_i),
        .regs_o     (regs_o)
    );

    // Measures how long the self-clearing bit (reg 6 bit 0) stays high.
    always @(negedge clk) begin
        if (rst_n) begin
            if (regs_o[6*8]) begin
                sw_hi_cycles++;
                if (sw_prev) sw_long++;
            end
            sw_prev = regs_o[6*8];
        end
    end

    function automatic logic [23:0] mk(input logic rw, input logic mark,
                                       input logic [13:0] a, input logic [7:0] d);
        return {rw, mark, a, d};
    endfunction

    function automatic logic [NREG*8-1:0] exp_flat();
        logic [NREG*8-1:0] v;
        for (int i = 0; i < NREG; i++) v[i*8 +: 8] = exp_reg[i];
        return v;
    endfunction

    task automatic exp_defaults();
        for (int i = 0; i < NREG; i++) exp_reg[i] = 8'hA0 + 8'(i);
    endtask

    task automatic check_regs(input string req);
        logic [NREG*8-1:0] e;
        e = exp_flat();
        total++;
        if (regs_o !== e) begin
            bad++;
            $display("FAIL %s: regs actual=%h expected=%h", req, regs_o, e);
        end
    endtask

    task automatic check_int(input string req, input int act, input int expv);
        total++;
        if (act != expv) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic open_win();
        @(negedge clk); #3;
        ser_en_n_i = 1'b0;
        #100;
    endtask

    task automatic close_win();
        #100;
        ser_en_n_i = 1'b1;
        #300;
        @(negedge clk);
    endtask

    // Shifts n bits MSB first; data set just after the fall.
    task automatic send_bits(input logic [127:0] bits, input int n,
                             input int hi_ns, input int lo_ns);
        for (int k = n - 1; k >= 0; k--) begin
            ser_data_i = bits[k];
            #(lo_ns);
            ser_clk_i = 1'b1;
            #(hi_ns);
            ser_clk_i = 1'b0;
        end
    endtask

    task automatic t_reset();
        exp_defaults();
        check_regs("R1 reset defaults");
    endtask

    task automatic t_single();
        open_win();
        send_bits(128'(mk(1'b0, 1'b1, 14'd2, 8'h5A)), 24, 100, 60);
        close_win();
        exp_reg[2] = 8'h5A;
        check_regs("R3 single write");
    endtask

    task automatic t_burst();
        open_win();
        send_bits({mk(1'b0, 1'b1, 14'd0, 8'h11), mk(1'b0, 1'b1, 14'd3, 8'h33),
                   mk(1'b0, 1'b1, 14'd0, 8'h22)}, 72, 100, 60);
        close_win();
        exp_reg[3] = 8'h33;
        exp_reg[0] = 8'h22;
        check_regs("R4 three frames one window");
    endtask

    task automatic t_partial();
        open_win();
        send_bits({mk(1'b0, 1'b1, 14'd4, 8'h44), 10'b0110000000}, 34, 100, 60);
        close_win();
        exp_reg[4] = 8'h44;
        check_regs("R5 trailing bits dropped");
        open_win();
        send_bits(128'(mk(1'b0, 1'b1, 14'd5, 8'h55)), 24, 100, 60);
        close_win();
        exp_reg[5] = 8'h55;
        check_regs("R5 new window restarts frame");
        open_win();
        send_bits(128'(mk(1'b0, 1'b1, 14'd1, 8'h99) >> 1), 23, 100, 60);
        close_win();
        check_regs("R5 23-bit window no write");
    endtask

    task automatic t_bad_frames();
        open_win();
        send_bits(128'(mk(1'b1, 1'b1, 14'd1, 8'hEE)), 24, 100, 60);
        close_win();
        check_regs("R6 read flag ignored");
        open_win();
        send_bits(128'(mk(1'b0, 1'b0, 14'd1, 8'hEE)), 24, 100, 60);
        close_win();
        check_regs("R6 marker zero ignored");
    endtask

    task automatic t_range();
        open_win();
        send_bits({mk(1'b0, 1'b1, 14'h2002, 8'h77), mk(1'b0, 1'b1, 14'd8, 8'h88)},
                  48, 100, 60);
        close_win();
        check_regs("R7 out of range ignored");
        open_win();
        send_bits(128'(mk(1'b0, 1'b1, 14'd7, 8'h3C)), 24, 100, 60);
        close_win();
        exp_reg[7] = 8'h3C;
        check_regs("R7 top address written");
    endtask

    task automatic t_idle_edges();
        ser_en_n_i = 1'b1;
        send_bits(128'(mk(1'b0, 1'b1, 14'd1, 8'hC1)), 24, 100, 60);
        #300; @(negedge clk);
        check_regs("R2 edges with enable high");
        open_win();
        send_bits(128'(mk(1'b0, 1'b1, 14'd1, 8'hC2)), 24, 100, 60);
        close_win();
        exp_reg[1] = 8'hC2;
        check_regs("R2 window after idle edges");
    endtask

    task automatic t_slow();
        open_win();
        send_bits(128'(mk(1'b0, 1'b1, 14'd6, 8'h6C)), 24, 3000, 500);
        close_win();
        exp_reg[6] = 8'h6C;
        check_regs("R10 slow serial clock");
        open_win();
        send_bits(128'(mk(1'b0, 1'b1, 14'd2, 8'hB2)), 24, 40, 200);
        close_win();
        exp_reg[2] = 8'hB2;
        check_regs("R10 short high phase");
    endtask

    task automatic t_sw_reset();
        sw_hi_cycles = 0;
        sw_long = 0;
        open_win();
        send_bits({mk(1'b0, 1'b1, 14'd6, 8'hF0), mk(1'b0, 1'b1, 14'd1, 8'h1F)},
                  48, 100, 60);
        close_win();
        exp_reg[6] = 8'hF0;
        exp_reg[1] = 8'h1F;
        check_regs("R8 reg6 written with bit0 clear");
        open_win();
        send_bits(128'(mk(1'b0, 1'b1, 14'd6, 8'h01)), 24, 100, 60);
        close_win();
        exp_defaults();
        check_regs("R8 software reset restores defaults");
        check_int("R8 reset bit high cycles", sw_hi_cycles, 1);
        check_int("R8 reset bit longer than one cycle", sw_long, 0);
    endtask

    task automatic t_hw_pulse();
        open_win();
        send_bits({mk(1'b0, 1'b1, 14'd3, 8'hD3), mk(1'b0, 1'b1, 14'd4, 8'hD4)},
                  48, 100, 60);
        close_win();
        exp_reg[3] = 8'hD3;
        exp_reg[4] = 8'hD4;
        check_regs("R3 writes before hw reset");
        @(negedge clk); hw_reset_i = 1'b1;
        @(negedge clk); hw_reset_i = 1'b0;
        exp_defaults();
        check_regs("R9 hw reset pulse");
    endtask

    task automatic t_hw_collide();
        logic [23:0] f;
        open_win();
        send_bits(128'(mk(1'b0, 1'b1, 14'd0, 8'h0F)), 24, 100, 60);
        f = mk(1'b0, 1'b1, 14'd5, 8'hE5);
        send_bits(128'(f[23:1]), 23, 100, 60);
        ser_data_i = f[0];
        #60;
        @(negedge clk); hw_reset_i = 1'b1;
        ser_clk_i = 1'b1;
        #100;
        ser_clk_i = 1'b0;
        #100;
        @(negedge clk); hw_reset_i = 1'b0;
        close_win();
        exp_defaults();
        check_regs("R9 hw reset beats completing frame");
    endtask

    initial begin
        #4_000_000;
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_single();
        t_burst();
        t_partial();
        t_bad_frames();
        t_range();
        t_idle_edges();
        t_slow();
        t_sw_reset();
        t_hw_pulse();
        t_hw_collide();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule